// File: doc/BRIEF.md
# Active-Priority Register Bank

This block keeps the record of which preemption levels currently have an interrupt of one group in service. The record is held in up to four 32-bit words, one bit per preemption level, with bit value 1 meaning "a handler at this level is running". Interrupt hardware sets a bit when it accepts an interrupt at a given 8-bit priority. It clears the most urgent set bit when that handler signals end of interrupt. The block reports the most urgent active priority back as status.

Software may read or replace any of the words. Every software access first passes a privilege gate. The gate takes the current privilege level, the hypervisor enable, the hypervisor trap bit and the per-level register-enable bits. From these it returns one of three results: data, an undefined-instruction fault, or a trap to the hypervisor with a syndrome code. A configuration input sets how many priority bits take part in preemption (5, 6 or 7). That number decides how priorities fold onto bits and which of the four words exist at all.

Top module: `actprio_bank`

## Requirements
- R1: After reset every bit of every word is 0, `top_valid` is 0 and `top_prio` is 0.
- R2: An access at privilege level 0 (`sw_el` = 0) always gives outcome undefined (`sw_status` = 2'b01). Outcome encoding: 2'b00 ok, 2'b01 undefined, 2'b10 trap. Outcome and syndrome follow the access fields combinationally.
- R3: At level 1, the outcome is trap (2'b10) with `sw_syndrome` = 8'h03 when `el2_en` and `trap_t12` are both 1; otherwise it is undefined. In every outcome other than trap the syndrome is 8'h00.
- R4: At level 2 an access can succeed only when `hyp_sre` is 1, and at level 3 only when `mon_sre` is 1. When the relevant bit is 0 the outcome is undefined.
- R5: The word index is `sw_opc2[1:0]`, and `sw_opc2[2]` must be 0. Word 0 always exists. Word 1 exists when `cfg_prebits` is 6 or 7. Words 2 and 3 exist only when it is 7. Any other value of `cfg_prebits` behaves as 5. At levels 2 and 3 with the enable set, an index with bit 2 set or a missing word gives undefined. At level 1 the trap check does not depend on the index.
- R6: `sw_rdata` shows the addressed word combinationally when `sw_req` is 1 and the outcome is ok. Otherwise it is 0.
- R7: A write (`sw_req` and `sw_wr`) with outcome ok replaces the whole word at the next clock edge. A write with any other outcome changes no stored bit.
- R8: With N preemption bits, `hw_activate` sets flat bit `hw_prio >> (8-N)`. The flat bit f lives in word f/32 at bit f%32. Priority bits below the preemption field do not matter.
- R9: `hw_eoi` clears the lowest-numbered set bit among the existing words only. Bits in words that do not exist are neither cleared nor reported.
- R10: When `hw_activate` and `hw_eoi` come in the same cycle, the clear is chosen from the state before that cycle, and then the set is applied. If both name the same bit, the bit ends set.
- R11: A write with outcome ok in a cycle drops that cycle's `hw_activate` and `hw_eoi` entirely.
- R12: `top_valid` is 1 when any existing bit is set. `top_prio` is then the lowest set flat index shifted left by 8-N, with the low bits 0. When no existing bit is set, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | Software access present |
| sw_wr | input | 1 | 1 = write, 0 = read |
| sw_opc2 | input | 3 | Access selector; bits [1:0] pick the word, bit 2 must be 0 |
| sw_el | input | 2 | Privilege level of the access (0..3) |
| el2_en | input | 1 | Hypervisor level enabled |
| trap_t12 | input | 1 | Hypervisor trap control for this register space |
| hyp_sre | input | 1 | Register-enable bit at level 2 |
| mon_sre | input | 1 | Register-enable bit at level 3 |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data |
| sw_status | output | 2 | Access outcome: 00 ok, 01 undefined, 10 trap |
| sw_syndrome | output | 8 | Syndrome code on trap, else 0 |
| hw_activate | input | 1 | Mark `hw_prio` active |
| hw_eoi | input | 1 | End of interrupt: clear most urgent active level |
| hw_prio | input | 8 | Priority for `hw_activate` |
| cfg_prebits | input | 3 | Implemented preemption bits (5, 6 or 7) |
| top_prio | output | 8 | Most urgent active priority |
| top_valid | output | 1 | Some existing bit is set |

## Verification
Two pairs of functions can land in one cycle. The first pair is a successful software write together with a hardware mark or end-of-interrupt. The second pair is a hardware mark together with an end-of-interrupt. The bench provokes each pair by driving both commands in the same clock period from a known state. It then reads the words back through the software port and compares them, and the reported top priority, with values worked out from the precedence rules. Dropped hardware commands, clears chosen from the state before the cycle, and the set-wins case on a shared bit each have their own stimulus.

// File: rtl/actprio_pkg.sv
package actprio_pkg;

    localparam int AP_NREG  = 4;
    localparam int AP_IDX_W = 2;

    typedef enum logic [1:0] {
        ACC_OK    = 2'b00,
        ACC_UNDEF = 2'b01,
        ACC_TRAP  = 2'b10
    } acc_outcome_e;

    typedef enum logic [1:0] {
        PRIV_USER   = 2'd0,
        PRIV_KERNEL = 2'd1,
        PRIV_HYP    = 2'd2,
        PRIV_MON    = 2'd3
    } priv_e;

    // number of words that exist for a preemption setting
    function automatic logic [2:0] ap_words(input logic [2:0] prebits);
        case (prebits)
            3'd7:    return 3'd4;
            3'd6:    return 3'd2;
            default: return 3'd1;
        endcase
    endfunction

    // right shift that folds a priority onto a flat level index
    function automatic logic [3:0] ap_shift(input logic [2:0] prebits, input int prio_w);
        case (prebits)
            3'd7:    return 4'(prio_w - 7);
            3'd6:    return 4'(prio_w - 6);
            default: return 4'(prio_w - 5);
        endcase
    endfunction

endpackage

// File: rtl/actprio_gate.sv
module actprio_gate
    import actprio_pkg::*;
#(
    parameter int SYN_W = 8,
    parameter logic [SYN_W-1:0] TRAP_CODE = 8'h03
) (
    input  logic [1:0]          el,
    input  logic                el2_en,
    input  logic                trap_t12,
    input  logic                hyp_sre,
    input  logic                mon_sre,
    input  logic [2:0]          opc2,
    input  logic [2:0]          prebits,
    output acc_outcome_e        outcome,
    output logic [AP_IDX_W-1:0] idx,
    output logic [SYN_W-1:0]    syndrome
);

    logic index_ok;

    assign idx      = opc2[AP_IDX_W-1:0];
    assign index_ok = !opc2[2] && ({1'b0, opc2[1:0]} < ap_words(prebits));

    always_comb begin
        outcome  = ACC_UNDEF;
        syndrome = '0;
        unique case (priv_e'(el))
            PRIV_USER: begin
                outcome = ACC_UNDEF;
            end
            PRIV_KERNEL: begin
                if (el2_en && trap_t12) begin
                    outcome  = ACC_TRAP;
                    syndrome = TRAP_CODE;
                end
            end
            PRIV_HYP: begin
                if (hyp_sre && index_ok) outcome = ACC_OK;
            end
            PRIV_MON: begin
                if (mon_sre && index_ok) outcome = ACC_OK;
            end
            default: begin
                outcome = ACC_UNDEF;
            end
        endcase
    end

endmodule

// File: rtl/actprio_map.sv
module actprio_map
    import actprio_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int PRIO_W = 8,
    localparam int TOTAL  = AP_NREG * WIDTH,
    localparam int FLAT_W = $clog2(TOTAL)
) (
    input  logic              activate,
    input  logic [PRIO_W-1:0] prio,
    input  logic [2:0]        prebits,
    output logic [TOTAL-1:0]  act_vec,
    output logic [TOTAL-1:0]  impl_mask,
    output logic [3:0]        shift
);

    logic [FLAT_W-1:0] flat;
    logic [2:0]        words;

    assign shift = ap_shift(prebits, PRIO_W);
    assign flat  = FLAT_W'(prio >> shift);
    assign words = ap_words(prebits);

    for (genvar i = 0; i < TOTAL; i++) begin : g_bit
        assign act_vec[i] = activate && (flat == FLAT_W'(i));
    end

    for (genvar r = 0; r < AP_NREG; r++) begin : g_word
        assign impl_mask[r*WIDTH +: WIDTH] = {WIDTH{(3'(r) < words)}};
    end

endmodule

// File: rtl/actprio_first.sv
module actprio_first #(
    parameter int N = 128,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/actprio_bank.sv
module actprio_bank
    import actprio_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int PRIO_W = 8,
    parameter int SYN_W  = 8,
    parameter logic [SYN_W-1:0] TRAP_CODE = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic              sw_wr,
    input  logic [2:0]        sw_opc2,
    input  logic [1:0]        sw_el,
    input  logic              el2_en,
    input  logic              trap_t12,
    input  logic              hyp_sre,
    input  logic              mon_sre,
    input  logic [WIDTH-1:0]  sw_wdata,
    output logic [WIDTH-1:0]  sw_rdata,
    output logic [1:0]        sw_status,
    output logic [SYN_W-1:0]  sw_syndrome,
    input  logic              hw_activate,
    input  logic              hw_eoi,
    input  logic [PRIO_W-1:0] hw_prio,
    input  logic [2:0]        cfg_prebits,
    output logic [PRIO_W-1:0] top_prio,
    output logic              top_valid
);

    localparam int TOTAL  = AP_NREG * WIDTH;
    localparam int FLAT_W = $clog2(TOTAL);

    logic [AP_NREG-1:0][WIDTH-1:0] state;
    logic [TOTAL-1:0]              act_vec;
    logic [TOTAL-1:0]              impl_mask;
    logic [TOTAL-1:0]              live;
    logic [TOTAL-1:0]              eoi_vec;
    logic [3:0]                    shift;
    logic                          first_found;
    logic [FLAT_W-1:0]             first_idx;
    acc_outcome_e                  outcome;
    logic [AP_IDX_W-1:0]           gate_idx;
    logic                          sw_write_ok;
    logic [PRIO_W+FLAT_W-1:0]      wide_prio;

    actprio_gate #(.SYN_W(SYN_W), .TRAP_CODE(TRAP_CODE)) u_gate (
        .el       (sw_el),
        .el2_en   (el2_en),
        .trap_t12 (trap_t12),
        .hyp_sre  (hyp_sre),
        .mon_sre  (mon_sre),
        .opc2     (sw_opc2),
        .prebits  (cfg_prebits),
        .outcome  (outcome),
        .idx      (gate_idx),
        .syndrome (sw_syndrome)
    );

    actprio_map #(.WIDTH(WIDTH), .PRIO_W(PRIO_W)) u_map (
        .activate  (hw_activate),
        .prio      (hw_prio),
        .prebits   (cfg_prebits),
        .act_vec   (act_vec),
        .impl_mask (impl_mask),
        .shift     (shift)
    );

    assign live = state & impl_mask;

    actprio_first #(.N(TOTAL)) u_first (
        .vec   (live),
        .found (first_found),
        .idx   (first_idx)
    );

    for (genvar i = 0; i < TOTAL; i++) begin : g_eoi
        assign eoi_vec[i] = hw_eoi && first_found && (first_idx == FLAT_W'(i));
    end

    assign sw_status   = outcome;
    assign sw_write_ok = sw_req && sw_wr && (outcome == ACC_OK);
    assign sw_rdata    = (sw_req && outcome == ACC_OK) ? state[gate_idx] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
        end else if (sw_write_ok) begin
            state[gate_idx] <= sw_wdata;
        end else begin
            state <= (state & ~eoi_vec) | act_vec;
        end
    end

    assign wide_prio = {{PRIO_W{1'b0}}, first_idx} << shift;
    assign top_prio  = first_found ? wide_prio[PRIO_W-1:0] : '0;
    assign top_valid = first_found;

    // support registers for the write-landing check
    logic                wl_pend;
    logic [AP_IDX_W-1:0] wl_idx;
    logic [WIDTH-1:0]    wl_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wl_pend <= 1'b0;
            wl_idx  <= '0;
            wl_data <= '0;
        end else begin
            wl_pend <= sw_write_ok;
            wl_idx  <= gate_idx;
            wl_data <= sw_wdata;
        end
    end

    // R2
    user_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_el == 2'd0) |-> (sw_status == 2'b01));

    // R3
    trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_status == 2'b10) |-> (sw_syndrome == TRAP_CODE && sw_el == 2'd1));

    // R7
    fault_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && sw_wr && sw_status != 2'b00 && !hw_activate && !hw_eoi) |=> $stable(state));

    // R7
    write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wl_pend |-> (state[wl_idx] == wl_data));

    // R9
    eoi_single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_eoi && !hw_activate && !sw_write_ok && top_valid)
        |=> ($countones(state) == $countones($past(state)) - 1));

    // R12
    empty_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !top_valid |-> (top_prio == '0));

endmodule

// File: tb/actprio_bank_test.sv
module actprio_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_req = 1'b0, sw_wr = 1'b0;
    logic [2:0]  sw_opc2 = '0;
    logic [1:0]  sw_el = '0;
    logic        el2_en = 1'b0, trap_t12 = 1'b0, hyp_sre = 1'b0, mon_sre = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic [1:0]  sw_status;
    logic [7:0]  sw_syndrome;
    logic        hw_activate = 1'b0, hw_eoi = 1'b0;
    logic [7:0]  hw_prio = '0;
    logic [2:0]  cfg_prebits = 3'd7;
    logic [7:0]  top_prio;
    logic        top_valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    actprio_bank uut (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_wr(sw_wr), .sw_opc2(sw_opc2),
        .sw_el(sw_el), .el2_en(el2_en), .trap_t12(trap_t12), .hyp_sre(hyp_sre),
        .mon_sre(mon_sre), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .sw_status(sw_status), .sw_syndrome(sw_syndrome), .hw_activate(hw_activate),
        .hw_eoi(hw_eoi), .hw_prio(hw_prio), .cfg_prebits(cfg_prebits),
        .top_prio(top_prio), .top_valid(top_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // expected outcome from the access rules
    function automatic logic [1:0] exp_outcome(input int el, input bit e2, input bit t12,
                                               input bit hs, input bit ms, input int op,
                                               input int cfg);
        int nw;
        nw = (cfg == 7) ? 4 : (cfg == 6) ? 2 : 1;
        if (el == 0) return 2'b01;
        if (el == 1) return (e2 && t12) ? 2'b10 : 2'b01;
        if (el == 2 && !hs) return 2'b01;
        if (el == 3 && !ms) return 2'b01;
        if (op >= 4) return 2'b01;
        if (op >= nw) return 2'b01;
        return 2'b00;
    endfunction

    task automatic sw_write(input logic [2:0] op, input logic [31:0] d);
        sw_req = 1'b1; sw_wr = 1'b1; sw_el = 2'd2; hyp_sre = 1'b1;
        sw_opc2 = op; sw_wdata = d;
        @(posedge clk); @(negedge clk);
        sw_req = 1'b0; sw_wr = 1'b0;
    endtask

    task automatic sw_read(input logic [2:0] op, output logic [31:0] d);
        sw_req = 1'b1; sw_wr = 1'b0; sw_el = 2'd2; hyp_sre = 1'b1; sw_opc2 = op;
        #1;
        d = sw_rdata;
        sw_req = 1'b0;
        #1;
    endtask

    task automatic clear_all;
        logic [2:0] keep;
        keep = cfg_prebits;
        cfg_prebits = 3'd7;
        for (int r = 0; r < 4; r++) sw_write(3'(r), 32'h0);
        cfg_prebits = keep;
    endtask

    task automatic hw_cmd(input bit act, input bit eoi, input logic [7:0] p);
        hw_activate = act; hw_eoi = eoi; hw_prio = p;
        @(posedge clk); @(negedge clk);
        hw_activate = 1'b0; hw_eoi = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: reset state
        chk("R1 top_valid", 32'(top_valid), 32'd0);
        chk("R1 top_prio", 32'(top_prio), 32'd0);
        for (int r = 0; r < 4; r++) begin
            sw_read(3'(r), d);
            chk("R1 word", d, 32'd0);
        end

        // R2 R3 R4 R5: outcome sweep over every access field combination
        for (int cfg = 5; cfg <= 7; cfg++) begin
            for (int el = 0; el < 4; el++) begin
                for (int c = 0; c < 16; c++) begin
                    for (int op = 0; op < 8; op++) begin
                        logic [1:0] e;
                        cfg_prebits = 3'(cfg); sw_el = 2'(el);
                        el2_en = c[0]; trap_t12 = c[1]; hyp_sre = c[2]; mon_sre = c[3];
                        sw_opc2 = 3'(op); sw_req = 1'b1; sw_wr = 1'b0;
                        #1;
                        e = exp_outcome(el, c[0], c[1], c[2], c[3], op, cfg);
                        chk("R2 R3 R4 R5 outcome", 32'(sw_status), 32'(e));
                        chk("R3 syndrome", 32'(sw_syndrome), (e == 2'b10) ? 32'h03 : 32'h0);
                        #1;
                    end
                end
            end
        end
        sw_req = 1'b0; el2_en = 1'b0; trap_t12 = 1'b0; mon_sre = 1'b0;

        // R8 R12: every priority under every preemption width
        for (int n = 5; n <= 7; n++) begin
            for (int p = 0; p < 256; p++) begin
                int sh, flat;
                cfg_prebits = 3'(n);
                clear_all();
                hw_cmd(1'b1, 1'b0, 8'(p));
                sh = 8 - n;
                flat = p >> sh;
                sw_read(3'(flat / 32), d);
                chk("R8 mapped bit", d, 32'h1 << (flat % 32));
                chk("R12 top_prio", 32'(top_prio), 32'((flat << sh) & 8'hff));
                chk("R12 top_valid", 32'(top_valid), 32'd1);
            end
        end

        // R6 R7: writes and reads that are not allowed
        cfg_prebits = 3'd7;
        clear_all();
        sw_write(3'd0, 32'hA5A5_0F0F);
        sw_read(3'd0, d);
        chk("R7 write lands", d, 32'hA5A5_0F0F);
        sw_req = 1'b1; sw_wr = 1'b0; sw_el = 2'd1; sw_opc2 = 3'd0; #1;
        chk("R6 faulted read zero", sw_rdata, 32'h0);
        sw_req = 1'b0; #1;
        sw_req = 1'b1; sw_wr = 1'b1; sw_el = 2'd1; el2_en = 1'b1; trap_t12 = 1'b1;
        sw_opc2 = 3'd0; sw_wdata = 32'hFFFF_FFFF;
        @(posedge clk); @(negedge clk);
        sw_req = 1'b0; sw_wr = 1'b0; el2_en = 1'b0; trap_t12 = 1'b0;
        sw_read(3'd0, d);
        chk("R7 trapped write ignored", d, 32'hA5A5_0F0F);
        sw_write(3'd4, 32'h0000_0001);
        sw_read(3'd0, d);
        chk("R7 R5 opc2 bit2 write ignored", d, 32'hA5A5_0F0F);
        cfg_prebits = 3'd6;
        sw_write(3'd2, 32'h0000_1234);
        cfg_prebits = 3'd7;
        sw_read(3'd2, d);
        chk("R7 R5 missing word write ignored", d, 32'h0);

        // R9: end-of-interrupt order across words
        clear_all();
        hw_cmd(1'b1, 1'b0, 8'h80);
        hw_cmd(1'b1, 1'b0, 8'h10);
        hw_cmd(1'b1, 1'b0, 8'hFE);
        hw_cmd(1'b1, 1'b0, 8'h42);
        chk("R12 top after marks", 32'(top_prio), 32'h10);
        hw_cmd(1'b0, 1'b1, 8'h00);
        chk("R9 eoi 1", 32'(top_prio), 32'h42);
        hw_cmd(1'b0, 1'b1, 8'h00);
        chk("R9 eoi 2", 32'(top_prio), 32'h80);
        hw_cmd(1'b0, 1'b1, 8'h00);
        chk("R9 eoi 3", 32'(top_prio), 32'hFE);
        hw_cmd(1'b0, 1'b1, 8'h00);
        chk("R9 eoi 4 valid", 32'(top_valid), 32'd0);
        chk("R12 empty prio", 32'(top_prio), 32'h0);

        // R9 R12: bits in words that do not exist are ignored
        hw_cmd(1'b1, 1'b0, 8'h80);
        cfg_prebits = 3'd5; #1;
        chk("R12 missing word hidden", 32'(top_valid), 32'd0);
        hw_cmd(1'b0, 1'b1, 8'h00);
        cfg_prebits = 3'd7; #1;
        chk("R9 missing word not cleared", 32'(top_prio), 32'h80);

        // R11: software write beats a same-cycle mark
        clear_all();
        sw_req = 1'b1; sw_wr = 1'b1; sw_el = 2'd2; hyp_sre = 1'b1;
        sw_opc2 = 3'd0; sw_wdata = 32'h0000_0004;
        hw_activate = 1'b1; hw_prio = 8'h02;
        @(posedge clk); @(negedge clk);
        sw_req = 1'b0; sw_wr = 1'b0; hw_activate = 1'b0;
        sw_read(3'd0, d);
        chk("R11 mark dropped", d, 32'h0000_0004);
        chk("R11 top", 32'(top_prio), 32'h04);

        // R11: software write beats a same-cycle eoi on another word
        sw_req = 1'b1; sw_wr = 1'b1; sw_opc2 = 3'd1; sw_wdata = 32'h0000_0001;
        hw_eoi = 1'b1;
        @(posedge clk); @(negedge clk);
        sw_req = 1'b0; sw_wr = 1'b0; hw_eoi = 1'b0;
        sw_read(3'd0, d);
        chk("R11 eoi dropped", d, 32'h0000_0004);
        sw_read(3'd1, d);
        chk("R11 written word", d, 32'h0000_0001);

        // R10: mark and eoi together
        clear_all();
        hw_cmd(1'b1, 1'b0, 8'h04);
        hw_cmd(1'b1, 1'b1, 8'h08);
        sw_read(3'd0, d);
        chk("R10 clear old then set", d, 32'h0000_0010);
        chk("R10 top", 32'(top_prio), 32'h08);
        hw_cmd(1'b1, 1'b1, 8'h08);
        sw_read(3'd0, d);
        chk("R10 same bit stays set", d, 32'h0000_0010);

        report();
        $finish;
    end

endmodule